// File: doc/BRIEF.md
# Double-Buffered Byte-to-Serial Loader

This block takes bytes from an asynchronous host bus and sends them out one bit per serial clock. The host writes a byte by asserting a write condition that combines two chip selects of opposite polarity, a write strobe and a read-select. When the condition ends, the block captures the byte into a one-byte holding stage. From there the byte passes into a shift register as soon as the shifter can take it.

A ready output tells the host when the holding stage can take another byte. The host can also read a status byte over the bus, whose top bit mirrors ready. The host marks the final byte with a flag. That byte sends only its first seven bits, and then the serial output freezes on its next-to-last bit and a halt flag rises. The block stays in this state until reset.

All logic runs on the serial clock. The write condition reaches the block through a two-flop synchronizer.

Top module: `byte_serial_loader`

## Requirements
- R1: The write condition is host_wr_n=0, host_sel_n=0, host_rd_n=1 and host_sel=1. A byte is captured only when this condition ends. Every other combination of the four control pins leaves ready high and ser_out high.
- R2: The first rising clk edge that samples the write condition as ended is edge 1. Ready reads low from the third such edge (edge 3) and stays low until the byte moves into the shift register.
- R3: If the shift register is empty, the byte moves two edges after capture. On that edge ready returns high and bit 0 of the byte appears on ser_out, so busy lasts two periods.
- R4: If the shift register is occupied, the byte moves exactly DW edges after the previous transfer. Ready is never low for more than DW consecutive periods.
- R5: Bits leave least significant bit first, each for one clk period. A byte written while the previous one is shifting follows it with no gap. With nothing to send, ser_out is 1.
- R6: When host_sel_n=0, host_sel=1, host_rd_n=0 and host_wr_n=1, stat_oe is 1 and stat_data is {ready, all ones}. For DW=8 that is 8'hFF when ready and 8'h7F when busy. Under any other pin combination, stat_oe is 0.
- R7: A byte written with host_last=1 sends only bits 0 to DW-2. DW-2 edges after its transfer, ser_out holds bit DW-2 and ser_halt rises. Both stay unchanged until reset.
- R8: If each write ends at least 11 clk periods after the previous one ends, every byte comes out intact without the host checking ready.
- R9: During and after reset, ready is 1, ser_out is 1, ser_halt is 0 and both the holding stage and the shift register are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | 1 | Active-low chip select |
| host_sel | input | 1 | Active-high chip select |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rd_n | input | 1 | Active-low read-select (high during writes) |
| host_data | input | DW | Byte written by the host |
| host_last | input | 1 | Marks the written byte as the final one |
| ser_out | output | 1 | Serial data, LSB first |
| ser_halt | output | 1 | High once the final byte has stopped |
| ready | output | 1 | High when the holding stage can take a byte |
| stat_oe | output | 1 | Status byte is being driven |
| stat_data | output | DW | Status byte: ready in the top bit, ones below |

## Verification
The bench uses the default DW=8. At this width the bench can send all 256 byte values through the loader without the host checking ready, and can try all 16 combinations of the four control pins. It also streams bytes in which the host waits on ready. There the shifter is always full, so the DW-edge transfer spacing and the longest busy window are reached on every byte. Sixteen final-byte runs check the seven-bit stop for both values of bit 6.

// File: rtl/byte_serial_loader.sv
module byte_serial_loader #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_n,
  input  logic          host_sel,
  input  logic          host_wr_n,
  input  logic          host_rd_n,
  input  logic [DW-1:0] host_data,
  input  logic          host_last,
  output logic          ser_out,
  output logic          ser_halt,
  output logic          ready,
  output logic          stat_oe,
  output logic [DW-1:0] stat_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DW);
  localparam logic [CW-1:0] LAST_CNT = CW'(DW - 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          wr_cond;
  logic [2:0]    wsync;
  logic          capture;
  logic [DW-1:0] stage, hold, sh;
  logic          stage_last, hold_last, sh_last;
  logic          hold_full, hold_aged;
  logic [CW-1:0] cnt;
  logic          xfer;
  logic [CW-1:0] busy_len;

  assign wr_cond   = !host_wr_n && !host_sel_n && host_rd_n && host_sel;
  assign capture   = wsync[2] && !wsync[1];
  assign ser_halt  = sh_last && (cnt == ONE);
  assign xfer      = hold_full && hold_aged && !ser_halt &&
                     ((cnt == '0) || (cnt == ONE && !sh_last));
  assign ser_out   = (cnt == '0) ? 1'b1 : sh[0];
  assign ready     = !hold_full;
  assign stat_oe   = !host_sel_n && host_sel && !host_rd_n && host_wr_n;
  assign stat_data = {ready, {(DW-1){1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync      <= '0;
      stage      <= '0;
      stage_last <= 1'b0;
      hold       <= '0;
      hold_last  <= 1'b0;
      hold_full  <= 1'b0;
      hold_aged  <= 1'b0;
    end else begin
      wsync <= {wsync[1:0], wr_cond};
      if (wsync[1]) begin
        stage      <= host_data;
        stage_last <= host_last;
      end
      if (capture) begin
        hold      <= stage;
        hold_last <= stage_last;
        hold_full <= 1'b1;
        hold_aged <= 1'b0;
      end else if (xfer) begin
        hold_full <= 1'b0;
        hold_aged <= 1'b0;
      end else begin
        hold_aged <= hold_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      sh_last <= 1'b0;
      cnt     <= '0;
    end else if (xfer) begin
      sh      <= hold;
      sh_last <= hold_last;
      cnt     <= hold_last ? LAST_CNT : FULL_CNT;
    end else if (cnt > ONE) begin
      sh  <= sh >> 1;
      cnt <= cnt - ONE;
    end else if (cnt == ONE && !sh_last) begin
      cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_len <= '0;
    else if (ready) busy_len <= '0;
    else if (busy_len != '1) busy_len <= busy_len + ONE;
  end

  AST_HOLD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !hold_full); // R1
  AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !ready); // R2
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= FULL_CNT); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > ONE) |=> (ser_out == $past(sh[1]))); // R5
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ser_halt |=> (ser_halt && $stable(ser_out))); // R7
endmodule

// File: tb/byte_serial_loader_tb.sv
`timescale 1ns/1ps
module byte_serial_loader_tb;
  localparam int DW = 8;
  localparam int N  = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1, lastb = 1'b0;
  logic [DW-1:0] data = '0;
  logic ser_out, ser_halt, ready, stat_oe;
  logic [DW-1:0] stat_data;

  byte_serial_loader #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_sel(sel),
    .host_wr_n(wr_n), .host_rd_n(rd_n), .host_data(data), .host_last(lastb),
    .ser_out(ser_out), .ser_halt(ser_halt), .ready(ready),
    .stat_oe(stat_oe), .stat_data(stat_data));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0, checks = 0, prev_t = -100;
  bit chk_on = 1'b0, done = 1'b0;
  string tag = "R9";
  bit exp_rdy[N];
  bit exp_ser[N];
  bit exp_halt[N];

  task automatic chk(string rq, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", rq, what, act, expv, cyc);
    end
  endtask

  task automatic chk8(string rq, logic [DW-1:0] act, logic [DW-1:0] expv, string what);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h cycle=%0d", rq, what, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_on && cyc < N) begin
      chk(tag, ready, exp_rdy[cyc], "ready");
      chk(tag, ser_out, exp_ser[cyc], "ser_out");
      chk(tag, ser_halt, exp_halt[cyc], "ser_halt");
    end
  end

  task automatic clear_from(int n);
    for (int i = n; i < N; i++) begin
      exp_rdy[i] = 1'b1; exp_ser[i] = 1'b1; exp_halt[i] = 1'b0;
    end
  endtask

  task automatic drive_idle();
    sel_n = 1'b1; sel = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic drive_write(logic [DW-1:0] d, logic l);
    data = d; lastb = l; sel_n = 1'b0; sel = 1'b1; rd_n = 1'b1; wr_n = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
    #1;
  endtask

  // rel: number of the first rising edge after the write condition ended
  task automatic note_write(int rel, logic [DW-1:0] d, logic l, output int t);
    int c;
    c = rel + 2;
    t = c + 2;
    if (prev_t + DW > t) t = prev_t + DW;
    for (int n = c; n < t && n < N; n++) exp_rdy[n] = 1'b0;
    for (int j = 0; j < (l ? DW-1 : DW); j++) if (t + j < N) exp_ser[t+j] = d[j];
    if (l) for (int n = t + DW - 2; n < N; n++) begin
      exp_ser[n] = d[DW-2]; exp_halt[n] = 1'b1;
    end
    prev_t = t;
  endtask

  task automatic do_reset();
    chk_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    drive_idle();
    repeat (2) @(negedge clk);
    clear_from(cyc);
    prev_t = -100;
    rst_n = 1'b1;
    chk_on = 1'b1;
  endtask

  task automatic hs_write(logic [DW-1:0] d, logic l, output int t);
    int rel;
    @(negedge clk);
    drive_write(d, l);
    repeat (2) @(negedge clk);
    while (!ready) @(negedge clk);
    @(negedge clk);
    drive_idle();
    rel = cyc + 1;
    note_write(rel, d, l, t);
    repeat (3) @(negedge clk);
  endtask

  task automatic spaced_write(logic [DW-1:0] d);
    int t;
    @(negedge clk);
    drive_write(d, 1'b0);
    repeat (2) @(negedge clk);
    drive_idle();
    note_write(cyc + 1, d, 1'b0, t);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int t, rel;
    logic [DW-1:0] d;
    clear_from(0);
    repeat (3) @(negedge clk);
    do_reset();
    #1;
    chk("R9", ready, 1'b1, "ready after reset");
    chk("R9", ser_out, 1'b1, "ser_out after reset");
    chk("R9", ser_halt, 1'b0, "ser_halt after reset");
    chk("R9", stat_oe, 1'b0, "stat_oe after reset");
    repeat (4) @(negedge clk);

    // single write, exact timing
    tag = "R2";
    d = 8'hB4;
    @(negedge clk);
    drive_write(d, 1'b0);
    repeat (3) @(negedge clk);
    drive_idle();
    rel = cyc + 1;
    note_write(rel, d, 1'b0, t);
    wait_cyc(rel + 1); chk("R2", ready, 1'b1, "ready one edge before capture");
    wait_cyc(rel + 2); chk("R2", ready, 1'b0, "ready at capture");
    wait_cyc(rel + 3); chk("R3", ready, 1'b0, "ready second busy period");
    chk("R3", ser_out, 1'b1, "ser_out before transfer");
    wait_cyc(rel + 4); chk("R3", ready, 1'b1, "ready after transfer");
    chk("R3", ser_out, d[0], "bit 0 at transfer");
    for (int j = 1; j < DW; j++) begin
      wait_cyc(t + j); chk("R5", ser_out, d[j], "serial bit");
    end
    wait_cyc(t + DW); chk("R5", ser_out, 1'b1, "idle level");

    // status read while busy and ready
    tag = "R6";
    hs_write(8'h96, 1'b0, t);
    sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
    #1;
    chk("R6", stat_oe, 1'b1, "stat_oe on read");
    chk8("R6", stat_data, 8'h7F, "status while busy");
    @(negedge clk); #1;
    chk8("R6", stat_data, 8'h7F, "status while busy");
    @(negedge clk); #1;
    chk8("R6", stat_data, 8'hFF, "status when ready");
    drive_idle();
    repeat (12) @(negedge clk);

    // all 16 control pin combinations
    tag = "R1";
    for (int v = 0; v < 16; v++) begin
      bit valid_wr, valid_rd;
      @(negedge clk);
      {sel_n, sel, wr_n, rd_n} = 4'(v);
      data = 8'h5A ^ 8'(v);
      lastb = 1'b0;
      valid_wr = (v == 4'b0101);
      valid_rd = (v == 4'b0110);
      #1;
      chk("R6", stat_oe, valid_rd, "stat_oe per pin combination");
      if (valid_rd) chk8("R6", stat_data, 8'hFF, "status idle");
      repeat (3) @(negedge clk);
      drive_idle();
      if (valid_wr) note_write(cyc + 1, 8'h5A ^ 8'(v), 1'b0, t);
      repeat (14) @(negedge clk);
    end

    // every byte value, writes 11 periods apart, no polling
    tag = "R8";
    for (int b = 0; b < 256; b++) spaced_write(8'(b));
    repeat (12) @(negedge clk);

    // polled back-to-back stream, shifter always occupied
    tag = "R4";
    for (int i = 0; i < 40; i++) hs_write(8'(i * 37 + 11), 1'b0, t);
    repeat (12) @(negedge clk);

    // final byte stops after seven bits
    tag = "R7";
    for (int k = 0; k < 16; k++) begin
      do_reset();
      hs_write(8'h3C ^ 8'(k), 1'b0, t);
      d = 8'(k * 17);
      hs_write(d, 1'b1, t);
      wait_cyc(t + DW - 3);
      chk("R7", ser_halt, 1'b0, "halt before final bit");
      wait_cyc(t + DW - 2);
      chk("R7", ser_halt, 1'b1, "halt raised");
      chk("R7", ser_out, d[DW-2], "held bit");
      repeat (20) @(negedge clk);
      #1;
      chk("R7", ser_out, d[DW-2], "bit still held");
      chk("R7", ser_halt, 1'b1, "halt still high");
    end

    do_reset();
    #1;
    chk("R9", ser_halt, 1'b0, "halt cleared by reset");
    chk("R9", ser_out, 1'b1, "ser_out after reset");
    repeat (4) @(negedge clk);
    chk_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule